// File: doc/BRIEF.md
# SRAM Bus Turnaround Scheduler

This block sits in front of a burst SRAM that has separate read and write commands and one shared, terminated DQ bus. Requests enter through a valid/ready pair, each tagged read or write. Every cycle the block issues exactly one command: a read, a write, a read-flavoured idle or a write-flavoured idle. The memory switches its own termination according to which idle flavour it receives, so each flavour has to land on the correct side of a change of bus direction.

When the direction changes, the scheduler first pads with idles of the old flavour. It then pads with idles of the new flavour before the real command goes out. Four run-time count inputs set the pad lengths. Each is raised to a hard floor: 0 write idles after a write, 0 read idles before a read, 2 read idles after a read and 3 write idles before a write. From the same command stream the block derives the controller's DQ termination enable and its drive-low enable. Out of reset the bus counts as being in the write direction, with termination off.

Top module: `sram_turn_sched`

## Requirements
- R1: Command codes on `cmd_o` are 2'b00 write idle, 2'b01 read idle, 2'b10 write and 2'b11 read. In the first cycle after reset, `cmd_o` is 2'b00, `term_en_o` is 0 and `drv_low_o` is 1.
- R2: A request accepted on a rising edge (valid and ready both high) appears on `cmd_o` in the following cycle. A request in the same direction as the last real command is ready at once, so back-to-back same-direction commands have no idles between them.
- R3: On a read-to-write change, at least max(`cnt_rd_tail`,2) read idles follow the last read. Exactly max(`cnt_wr_lead`,3) write idles then come before the write.
- R4: On a write-to-read change, at least `cnt_wr_tail` write idles follow the last write. Exactly `cnt_rd_lead` read idles then come before the read.
- R5: A count input below its floor (0, 0, 2, 3 for write-tail, read-lead, read-tail, write-lead) acts as the floor. For example, `cnt_rd_tail`=1 gives exactly 2 read idles when a write request is waiting.
- R6: With no request pending, the idles issued match the flavour of the last real command. After reset, when no command has been issued yet, they are write idles.
- R7: A request of the opposite direction keeps `req_ready` low until all old-flavour idles and then all new-flavour idles have been issued. The first read after reset is handled as a write-to-read change.
- R8: `term_en_o` is 1 in exactly those cycles whose previous `cmd_o` was a read or a read idle.
- R9: `drv_low_o` is 1 in exactly those cycles whose previous `cmd_o` was a write idle. It is therefore never high together with `term_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_is_read | input | 1 | 1 = read request, 0 = write request |
| req_ready | output | 1 | Request accepted on this edge when valid |
| cnt_wr_tail | input | CNT_W | Write idles after the last write (floor 0) |
| cnt_rd_lead | input | CNT_W | Read idles before the first read (floor 0) |
| cnt_rd_tail | input | CNT_W | Read idles after the last read (floor 2) |
| cnt_wr_lead | input | CNT_W | Write idles before the first write (floor 3) |
| cmd_o | output | 2 | Command issued this cycle |
| term_en_o | output | 1 | Controller DQ termination enable |
| drv_low_o | output | 1 | Controller DQ drive-low enable |

## Verification
The checks assume the standard valid/ready rule: once `req_valid` is raised, it and `req_is_read` stay unchanged until the request is accepted. They also assume the count inputs change only while the bus idles in steady state, never while a turnaround is being padded. The stimulus raises a request at a falling edge and holds it until `req_ready` is seen high. It changes the counts only after a long run of idle cycles with no request pending, so every turnaround is judged against a single set of counts.

// File: rtl/turn_pkg.sv
package turn_pkg;
    typedef enum logic [1:0] {
        C_NOPW  = 2'b00,
        C_NOPR  = 2'b01,
        C_WRITE = 2'b10,
        C_READ  = 2'b11
    } cmd_e;

    localparam int unsigned N_CNT = 4;
    // slot order in the count array
    localparam int unsigned S_WR_TAIL = 0;
    localparam int unsigned S_RD_LEAD = 1;
    localparam int unsigned S_RD_TAIL = 2;
    localparam int unsigned S_WR_LEAD = 3;

    function automatic int unsigned floor_of(input int unsigned slot);
        case (slot)
            S_RD_TAIL: floor_of = 2;
            S_WR_LEAD: floor_of = 3;
            default:   floor_of = 0;
        endcase
    endfunction

    function automatic cmd_e idle_of(input logic is_rd);
        idle_of = is_rd ? C_NOPR : C_NOPW;
    endfunction

    function automatic cmd_e real_of(input logic is_rd);
        real_of = is_rd ? C_READ : C_WRITE;
    endfunction
endpackage

// File: rtl/turn_cnt_clamp.sv
module turn_cnt_clamp
    import turn_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic [N_CNT-1:0][CNT_W-1:0] raw_i,
    output logic [N_CNT-1:0][CNT_W-1:0] eff_o
);
    for (genvar g = 0; g < N_CNT; g++) begin : g_slot
        localparam logic [CNT_W-1:0] FLOOR = CNT_W'(floor_of(g));
        assign eff_o[g] = (raw_i[g] < FLOOR) ? FLOOR : raw_i[g];
    end
endmodule

// File: rtl/turn_fsm.sv
module turn_fsm
    import turn_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_is_read,
    output logic                        req_ready,
    input  logic [N_CNT-1:0][CNT_W-1:0] eff_i,
    output cmd_e                        cmd_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             dir_q, dir_d;      // 1 = read direction
    logic             lead_q, lead_d;    // padding new-direction idles
    logic [CNT_W-1:0] tail_q, tail_d;
    logic [CNT_W-1:0] lcnt_q, lcnt_d;
    cmd_e             cmd_q, cmd_d;

    logic [CNT_W-1:0] need_tail, need_lead_new, need_lead_cur;
    logic [CNT_W-1:0] tail_inc;

    assign need_tail     = dir_q ? eff_i[S_RD_TAIL] : eff_i[S_WR_TAIL];
    assign need_lead_new = dir_q ? eff_i[S_WR_LEAD] : eff_i[S_RD_LEAD];
    assign need_lead_cur = dir_q ? eff_i[S_RD_LEAD] : eff_i[S_WR_LEAD];
    assign tail_inc      = (tail_q == CNT_MAX) ? tail_q : tail_q + 1'b1;

    always_comb begin
        dir_d     = dir_q;
        lead_d    = lead_q;
        tail_d    = tail_q;
        lcnt_d    = lcnt_q;
        cmd_d     = idle_of(dir_q);
        req_ready = 1'b0;
        if (lead_q) begin
            if (lcnt_q < need_lead_cur) begin
                lcnt_d = lcnt_q + 1'b1;
            end else begin
                req_ready = (req_is_read == dir_q);
                if (req_valid && req_ready) begin
                    cmd_d  = real_of(dir_q);
                    lead_d = 1'b0;
                    tail_d = '0;
                end
            end
        end else if (req_is_read == dir_q) begin
            req_ready = 1'b1;
            if (req_valid) begin
                cmd_d  = real_of(dir_q);
                tail_d = '0;
            end else begin
                tail_d = tail_inc;
            end
        end else begin
            req_ready = (tail_q >= need_tail) && (need_lead_new == '0);
            if (!req_valid || tail_q < need_tail) begin
                tail_d = tail_inc;
            end else if (need_lead_new == '0) begin
                cmd_d  = real_of(req_is_read);
                dir_d  = req_is_read;
                tail_d = '0;
            end else begin
                cmd_d  = idle_of(req_is_read);
                dir_d  = req_is_read;
                lead_d = 1'b1;
                lcnt_d = CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= 1'b0;
            lead_q <= 1'b0;
            tail_q <= '0;
            lcnt_q <= '0;
            cmd_q  <= C_NOPW;
        end else begin
            dir_q  <= dir_d;
            lead_q <= lead_d;
            tail_q <= tail_d;
            lcnt_q <= lcnt_d;
            cmd_q  <= cmd_d;
        end
    end

    assign cmd_o = cmd_q;
endmodule

// File: rtl/turn_term.sv
module turn_term
    import turn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd_i,
    output logic term_en_o,
    output logic drv_low_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            term_en_o <= 1'b0;
            drv_low_o <= 1'b1;
        end else begin
            term_en_o <= (cmd_i == C_READ) || (cmd_i == C_NOPR);
            drv_low_o <= (cmd_i == C_NOPW);
        end
    end
endmodule

// File: rtl/sram_turn_sched.sv
module sram_turn_sched
    import turn_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_is_read,
    output logic             req_ready,
    input  logic [CNT_W-1:0] cnt_wr_tail,
    input  logic [CNT_W-1:0] cnt_rd_lead,
    input  logic [CNT_W-1:0] cnt_rd_tail,
    input  logic [CNT_W-1:0] cnt_wr_lead,
    output logic [1:0]       cmd_o,
    output logic             term_en_o,
    output logic             drv_low_o
);
    logic [N_CNT-1:0][CNT_W-1:0] raw_cnt, eff_cnt;
    cmd_e cmd_w;

    assign raw_cnt[S_WR_TAIL] = cnt_wr_tail;
    assign raw_cnt[S_RD_LEAD] = cnt_rd_lead;
    assign raw_cnt[S_RD_TAIL] = cnt_rd_tail;
    assign raw_cnt[S_WR_LEAD] = cnt_wr_lead;

    turn_cnt_clamp #(.CNT_W(CNT_W)) clamp_i (
        .raw_i (raw_cnt),
        .eff_o (eff_cnt)
    );

    turn_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_is_read (req_is_read),
        .req_ready   (req_ready),
        .eff_i       (eff_cnt),
        .cmd_o       (cmd_w)
    );

    turn_term term_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd_w),
        .term_en_o (term_en_o),
        .drv_low_o (drv_low_o)
    );

    assign cmd_o = cmd_w;
endmodule

// File: rtl/sram_turn_sched_chk.sv
module sram_turn_sched_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_is_read,
    input logic       req_ready,
    input logic [1:0] cmd_o,
    input logic       term_en_o,
    input logic       drv_low_o
);
    // R2
    accept_to_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cmd_o == {1'b1, $past(req_is_read)}));

    // R6
    idle_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 2'b11 && !req_valid) |=> (cmd_o == 2'b01));

    // R7
    no_quick_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 2'b11) |-> !(req_valid && !req_is_read && req_ready));

    // R8
    term_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o[0] == 1'b1) |=> term_en_o);

    // R9
    low_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 2'b00) |=> (drv_low_o && !term_en_o));
endmodule

bind sram_turn_sched sram_turn_sched_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_is_read (req_is_read),
    .req_ready   (req_ready),
    .cmd_o       (cmd_o),
    .term_en_o   (term_en_o),
    .drv_low_o   (drv_low_o)
);

// File: tb/sram_turn_sched_tb_top.sv
module sram_turn_sched_tb_top;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_is_read = 1'b0;
    logic          req_ready;
    logic [CW-1:0] c_wt = '0, c_rl = '0, c_rt = '0, c_wl = '0;
    logic [1:0]    cmd_o;
    logic          term_en_o, drv_low_o;

    int n_chk = 0, n_fail = 0;
    bit exact_tail = 0;
    bit mon_on = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sram_turn_sched #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_read(req_is_read),
        .req_ready(req_ready), .cnt_wr_tail(c_wt), .cnt_rd_lead(c_rl),
        .cnt_rd_tail(c_rt), .cnt_wr_lead(c_wl), .cmd_o(cmd_o),
        .term_en_o(term_en_o), .drv_low_o(drv_low_o));

    function automatic int eff(input logic [CW-1:0] v, input int fl);
        return (int'(v) < fl) ? fl : int'(v);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stream monitor: idle runs between real commands, termination outputs
    logic [1:0] prev_cmd = 2'b00;
    bit last_rd = 0;
    int old_run = 0, new_run = 0;
    bit bad_order = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            check(term_en_o == prev_cmd[0], "R8 term_en", term_en_o, prev_cmd[0]);
            check(drv_low_o == (prev_cmd == 2'b00), "R9 drv_low", drv_low_o, prev_cmd == 2'b00);
            if (term_en_o && drv_low_o) check(0, "R9 both high", 1, 0);
            if (!cmd_o[1]) begin
                if (cmd_o[0] == last_rd) begin
                    if (new_run > 0) bad_order = 1;
                    old_run++;
                end else begin
                    new_run++;
                end
            end else begin
                if (cmd_o[0] == last_rd) begin
                    check(new_run == 0, "R2 same-direction idles", new_run, 0);
                end else if (!last_rd) begin
                    check(!bad_order, "R7 idle order", bad_order, 0);
                    check(old_run >= eff(c_wt, 0), "R4 write tail", old_run, eff(c_wt, 0));
                    check(new_run == eff(c_rl, 0), "R4 read lead", new_run, eff(c_rl, 0));
                end else begin
                    check(!bad_order, "R7 idle order", bad_order, 0);
                    check(old_run >= eff(c_rt, 2), "R3 read tail", old_run, eff(c_rt, 2));
                    if (exact_tail)
                        check(old_run == eff(c_rt, 2), "R5 read tail clamp", old_run, eff(c_rt, 2));
                    check(new_run == eff(c_wl, 3), "R3 write lead", new_run, eff(c_wl, 3));
                end
                last_rd = cmd_o[0];
                old_run = 0; new_run = 0; bad_order = 0;
            end
            prev_cmd = cmd_o;
        end
    end

    task automatic send(input bit rd);
        @(negedge clk);
        req_valid = 1'b1; req_is_read = rd;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(cmd_o == 2'b00, "R1 reset cmd", cmd_o, 0);
        check(term_en_o == 0, "R1 reset term", term_en_o, 0);
        check(drv_low_o == 1, "R1 reset drv_low", drv_low_o, 1);
        mon_on = 1;
        @(negedge clk);
        // R6 idles after reset are write idles
        check(cmd_o == 2'b00, "R6 reset idle", cmd_o, 0);

        // R2 back-to-back writes, accepted on consecutive edges
        send(0); send(0); send(0);
        @(negedge clk); req_valid = 0;
        check(cmd_o == 2'b10, "R2 write issued", cmd_o, 2);
        idle(2);

        // R7 first read after reset is a write-to-read change; R4 with lead 3
        c_rl = 4'd3;
        @(negedge clk);
        req_valid = 1; req_is_read = 1; #1;
        check(req_ready == 0, "R7 ready low before read lead", req_ready, 0);
        send(1); send(1);
        idle(3);
        // R6 idles after a read are read idles
        check(cmd_o == 2'b01, "R6 idle after read", cmd_o, 1);

        // R7 opposite request held off; R5 clamp of read tail 1 -> 2
        c_rt = 4'd1; c_wl = 4'd0;
        send(1);
        exact_tail = 1;
        @(negedge clk);
        req_valid = 1; req_is_read = 0; #1;
        check(req_ready == 0, "R7 ready low before write", req_ready, 0);
        send(0);
        idle(2);
        exact_tail = 0;

        // R3 larger counts, exact tail when write waits
        c_rt = 4'd5; c_wl = 4'd4;
        idle(20);
        send(1);
        exact_tail = 1;
        send(0);
        idle(2);
        exact_tail = 0;

        // random mix
        for (int blk = 0; blk < 6; blk++) begin
            idle(25);
            c_wt = CW'($urandom_range(0, 6)); c_rl = CW'($urandom_range(0, 6));
            c_rt = CW'($urandom_range(0, 7)); c_wl = CW'($urandom_range(0, 7));
            for (int k = 0; k < 60; k++) begin
                send(1'($urandom_range(0, 1)));
                if ($urandom_range(0, 3) == 0) idle($urandom_range(0, 4));
            end
        end
        idle(10);
        done = 1;
    end

    initial begin
        void'($urandom(32'd1234));
        fork
            begin wait (done); end
            begin
                repeat (150000) @(posedge clk);
                check(0, "watchdog", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule